// File: doc/BRIEF.md
# Dual-Target Address Translation Unit

This block sits inside a network interface and turns 32-bit virtual addresses issued by on-chip requesters into physical addresses. A translation lands in one of two spaces: a 28-bit address in the interface's local memory, or a 48-bit address on the host bus. Pages are 4 KB, so the low twelve bits pass through unchanged while the upper twenty bits select a page.

Recent translations live in a small fully associative lookaside buffer. A request that hits returns one cycle after it is accepted. A request that misses drops the ready signal and starts a built-in walker. The walker fetches one 64-bit page-table entry through a plain read port and fills the buffer when that entry is present. A walk that finds no mapping, or an access that breaks the write permission, is reported on the response and captured in a sticky fault register that software clears. A single-pulse input drops every cached translation at once.

Top module: `addr_xlate_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, mem_rd_valid and fault_valid are 0, and every buffer slot is empty, so the first access to any page walks.
- R2: A request accepted (req_valid and req_ready both 1) whose page is cached gives a single-cycle rsp_valid pulse on the next cycle, issues no table read, and copies vaddr bits 11:0 to rsp_paddr bits 11:0.
- R3: A local-space translation gives rsp_host=0, the low 16 bits of the stored frame number in rsp_paddr[27:12] and zeros in rsp_paddr[47:28]. A host-space translation gives rsp_host=1 with the 36-bit frame number in rsp_paddr[47:12].
- R4: On a miss, req_ready falls and mem_rd_valid rises in the cycle after acceptance, with mem_rd_addr = TABLE_BASE + 8*vaddr[31:12]. The address holds steady until mem_rd_ack. The response appears in the cycle after the ack, and req_ready returns at the same time.
- R5: A table entry is decoded as: bit 0 present, bit 1 host space, bit 2 writable, bits 47:12 frame number. A present entry is written into the buffer, so the next access to that page hits.
- R6: An entry with bit 0 clear yields rsp_fault=1, rsp_paddr=0 and rsp_host=0. Nothing is cached, so a repeat access walks again. The fault cause is 1 (no mapping).
- R7: A request with req_write=1 to a page whose writable bit is 0 yields rsp_fault=1 with cause 2 (permission), whether it hit or walked. Reads of that page translate normally, and the walked entry is still cached.
- R8: The fault register loads fault_vaddr and fault_cause on a fault only while it is empty. It keeps them until a fault_clear pulse empties it. A fault in the same cycle as fault_clear is loaded.
- R9: A fill goes to the lowest-numbered empty slot. When all ENTRIES slots are full, the victim is chosen by a round-robin pointer that is 0 after reset, advances by one for each replacement, and is not moved by invalidation.
- R10: A one-cycle inval_all pulse empties every slot, so the next access to any page walks. A fill in that same cycle is discarded. A hit accepted in that cycle still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_host | output | 1 | 1 = host-bus address, 0 = local memory |
| rsp_paddr | output | 48 | Physical address (zero on a fault) |
| mem_rd_valid | output | 1 | Walker read request |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 64 | Table entry |
| inval_all | input | 1 | Empty every buffer slot |
| fault_clear | input | 1 | Empty the fault register |
| fault_valid | output | 1 | Fault register holds a fault |
| fault_vaddr | output | 32 | Faulting virtual address |
| fault_cause | output | 2 | 1 = no mapping, 2 = permission |

## Verification
The properties assume that the table memory raises mem_rd_ack only while mem_rd_valid is high and for one cycle per read. They also assume that requesters present req_valid only when they are ready to see a response on a later cycle. The bench's memory responder answers each read exactly once, after a chosen delay of zero to three cycles. It drives inval_all and fault_clear only as one-cycle pulses at the edges it means to exercise. A behavioural model of the buffer slots, the victim pointer and the fault register predicts, for each request, whether it hits, which address is read and what comes back.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    localparam int VA_W         = 32;
    localparam int PAGE_W       = 12;
    localparam int VPN_W        = VA_W - PAGE_W;
    localparam int LOCAL_PA_W   = 28;
    localparam int HOST_PA_W    = 48;
    localparam int PPN_W        = HOST_PA_W - PAGE_W;
    localparam int LOCAL_PPN_W  = LOCAL_PA_W - PAGE_W;
    localparam int PTE_W        = 64;
    localparam int PTE_BYTES_LG = 3;

    // table entry bit positions
    localparam int PTE_PRESENT  = 0;
    localparam int PTE_HOST     = 1;
    localparam int PTE_WRITE    = 2;

    typedef struct packed {
        logic              valid;
        logic              host;
        logic              writable;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_NOMAP = 2'd1,
        CAUSE_PERM  = 2'd2
    } fault_cause_e;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_READ = 1'b1
    } walk_state_e;

    // Decode a fetched table entry; local frames keep only the bits that fit.
    function automatic tlb_entry_t entry_from_pte(input logic [VPN_W-1:0] vpn,
                                                  input logic [PTE_W-1:0] pte);
        tlb_entry_t e;
        e.valid    = pte[PTE_PRESENT];
        e.host     = pte[PTE_HOST];
        e.writable = pte[PTE_WRITE];
        e.vpn      = vpn;
        e.ppn      = pte[PAGE_W +: PPN_W];
        if (!e.host) e.ppn[PPN_W-1:LOCAL_PPN_W] = '0;
        return e;
    endfunction

    function automatic logic [HOST_PA_W-1:0] form_paddr(input tlb_entry_t e,
                                                        input logic [PAGE_W-1:0] off);
        return {e.ppn, off};
    endfunction

endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inval_all,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output tlb_entry_t       lk_entry,
    input  logic             fill_en,
    input  tlb_entry_t       fill_entry
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_entry_t          slots [ENTRIES];
    logic [ENTRIES-1:0]  match;
    logic [ENTRIES-1:0]  occupied;
    logic [IDX_W-1:0]    rr_ptr;
    logic [IDX_W-1:0]    free_idx;
    logic                free_found;
    logic [IDX_W-1:0]    victim;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign occupied[g] = slots[g].valid;
            assign match[g]    = slots[g].valid && (slots[g].vpn == lk_vpn);
        end
    endgenerate

    always_comb begin
        lk_hit   = |match;
        lk_entry = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_entry = slots[i];
        end
    end

    // lowest empty slot wins
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occupied[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign victim = free_found ? free_idx : rr_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
            rr_ptr <= '0;
        end else if (inval_all) begin
            for (int i = 0; i < ENTRIES; i++) slots[i].valid <= 1'b0;
        end else if (fill_en) begin
            slots[victim] <= fill_entry;
            if (!free_found) begin
                rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xlate_pkg::*;
#(
    parameter logic [VA_W-1:0] TABLE_BASE = 32'h0010_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VPN_W-1:0] start_vpn,
    output logic             busy,
    output logic             mem_rd_valid,
    output logic [VA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_ack,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic             done,
    output logic [PTE_W-1:0] done_pte
);
    walk_state_e      state;
    logic [VPN_W-1:0] vpn_q;

    assign busy         = (state == WALK_READ);
    assign mem_rd_valid = (state == WALK_READ);
    assign mem_rd_addr  = TABLE_BASE + (VA_W'(vpn_q) << PTE_BYTES_LG);
    assign done         = (state == WALK_READ) && mem_rd_ack;
    assign done_pte     = mem_rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WALK_IDLE;
            vpn_q <= '0;
        end else begin
            case (state)
                WALK_IDLE: if (start) begin
                    state <= WALK_READ;
                    vpn_q <= start_vpn;
                end
                WALK_READ: if (mem_rd_ack) state <= WALK_IDLE;
                default:   state <= WALK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xlate_fault_reg.sv
module xlate_fault_reg
    import xlate_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set,
    input  logic [VA_W-1:0] set_vaddr,
    input  fault_cause_e    set_cause,
    input  logic            clear,
    output logic            valid,
    output logic [VA_W-1:0] vaddr,
    output logic [1:0]      cause
);
    logic            valid_q;
    logic [VA_W-1:0] vaddr_q;
    fault_cause_e    cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            vaddr_q <= '0;
            cause_q <= CAUSE_NONE;
        end else if (set && (!valid_q || clear)) begin
            valid_q <= 1'b1;
            vaddr_q <= set_vaddr;
            cause_q <= set_cause;
        end else if (clear) begin
            valid_q <= 1'b0;
            vaddr_q <= '0;
            cause_q <= CAUSE_NONE;
        end
    end

    assign valid = valid_q;
    assign vaddr = vaddr_q;
    assign cause = cause_q;

endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
    import xlate_pkg::*;
#(
    parameter int               ENTRIES    = 16,
    parameter logic [VA_W-1:0]  TABLE_BASE = 32'h0010_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic                 req_write,
    output logic                 rsp_valid,
    output logic                 rsp_fault,
    output logic                 rsp_host,
    output logic [HOST_PA_W-1:0] rsp_paddr,
    output logic                 mem_rd_valid,
    output logic [VA_W-1:0]      mem_rd_addr,
    input  logic                 mem_rd_ack,
    input  logic [PTE_W-1:0]     mem_rd_data,
    input  logic                 inval_all,
    input  logic                 fault_clear,
    output logic                 fault_valid,
    output logic [VA_W-1:0]      fault_vaddr,
    output logic [1:0]           fault_cause
);
    logic             busy;
    logic             accept;
    logic             lk_hit;
    tlb_entry_t       lk_entry;
    logic             walk_start;
    logic             walk_done;
    logic [PTE_W-1:0] walk_pte;
    tlb_entry_t       walk_entry;
    logic [VA_W-1:0]  pend_vaddr;
    logic             pend_write;

    logic             fin_valid;
    tlb_entry_t       fin_entry;
    logic             fin_write;
    logic [VA_W-1:0]  fin_vaddr;
    fault_cause_e     fin_cause;

    logic                 rsp_valid_q;
    logic                 rsp_fault_q;
    logic                 rsp_host_q;
    logic [HOST_PA_W-1:0] rsp_paddr_q;

    assign req_ready  = !busy && !rst;
    assign accept     = req_valid && req_ready;
    assign walk_start = accept && !lk_hit;
    assign walk_entry = entry_from_pte(pend_vaddr[VA_W-1:PAGE_W], walk_pte);

    xlate_tlb #(.ENTRIES(ENTRIES)) u_tlb (
        .clk        (clk),
        .rst        (rst),
        .inval_all  (inval_all),
        .lk_vpn     (req_vaddr[VA_W-1:PAGE_W]),
        .lk_hit     (lk_hit),
        .lk_entry   (lk_entry),
        .fill_en    (walk_done && walk_entry.valid),
        .fill_entry (walk_entry)
    );

    xlate_walker #(.TABLE_BASE(TABLE_BASE)) u_walk (
        .clk          (clk),
        .rst          (rst),
        .start        (walk_start),
        .start_vpn    (req_vaddr[VA_W-1:PAGE_W]),
        .busy         (busy),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_ack   (mem_rd_ack),
        .mem_rd_data  (mem_rd_data),
        .done         (walk_done),
        .done_pte     (walk_pte)
    );

    // request held while the walk runs
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vaddr <= '0;
            pend_write <= 1'b0;
        end else if (walk_start) begin
            pend_vaddr <= req_vaddr;
            pend_write <= req_write;
        end
    end

    // finishing translation: either a hit this cycle or a completed walk
    always_comb begin
        if (walk_done) begin
            fin_valid = 1'b1;
            fin_entry = walk_entry;
            fin_write = pend_write;
            fin_vaddr = pend_vaddr;
        end else begin
            fin_valid = accept && lk_hit;
            fin_entry = lk_entry;
            fin_write = req_write;
            fin_vaddr = req_vaddr;
        end
        if (!fin_entry.valid)                     fin_cause = CAUSE_NOMAP;
        else if (fin_write && !fin_entry.writable) fin_cause = CAUSE_PERM;
        else                                      fin_cause = CAUSE_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_fault_q <= 1'b0;
            rsp_host_q  <= 1'b0;
            rsp_paddr_q <= '0;
        end else begin
            rsp_valid_q <= fin_valid;
            rsp_fault_q <= fin_valid && (fin_cause != CAUSE_NONE);
            rsp_host_q  <= fin_valid && (fin_cause == CAUSE_NONE) && fin_entry.host;
            rsp_paddr_q <= (fin_valid && fin_cause == CAUSE_NONE)
                         ? form_paddr(fin_entry, fin_vaddr[PAGE_W-1:0]) : '0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_fault = rsp_fault_q;
    assign rsp_host  = rsp_host_q;
    assign rsp_paddr = rsp_paddr_q;

    xlate_fault_reg u_fault (
        .clk       (clk),
        .rst       (rst),
        .set       (fin_valid && (fin_cause != CAUSE_NONE)),
        .set_vaddr (fin_vaddr),
        .set_cause (fin_cause),
        .clear     (fault_clear),
        .valid     (fault_valid),
        .vaddr     (fault_vaddr),
        .cause     (fault_cause)
    );

endmodule

// File: rtl/xlate_checks.sv
module xlate_checks
    import xlate_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 rsp_valid,
    input logic                 rsp_fault,
    input logic                 rsp_host,
    input logic [HOST_PA_W-1:0] rsp_paddr,
    input logic                 mem_rd_valid,
    input logic [VA_W-1:0]      mem_rd_addr,
    input logic                 mem_rd_ack,
    input logic                 fault_clear,
    input logic                 fault_valid,
    input logic [VA_W-1:0]      fault_vaddr,
    input logic [1:0]           fault_cause
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !mem_rd_valid && !fault_valid));

    p_rsp_source_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rd_valid && mem_rd_ack)));

    p_local_range_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_host) |-> (rsp_paddr[HOST_PA_W-1:LOCAL_PA_W] == '0));

    p_stall_r4: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !req_ready);

    p_rd_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    p_fault_blank_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_host));

    p_cause_code_r6: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (fault_cause == 2'd1 || fault_cause == 2'd2));

    p_fault_logged_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> fault_valid);

    p_fault_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_valid && !fault_clear) |=>
            (fault_valid && $stable(fault_vaddr) && $stable(fault_cause)));

endmodule

bind addr_xlate_unit xlate_checks u_checks (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_host     (rsp_host),
    .rsp_paddr    (rsp_paddr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ack   (mem_rd_ack),
    .fault_clear  (fault_clear),
    .fault_valid  (fault_valid),
    .fault_vaddr  (fault_vaddr),
    .fault_cause  (fault_cause)
);

// File: tb/addr_xlate_unit_test.sv
`timescale 1ns/1ps
module addr_xlate_unit_test;

    localparam int          N    = 16;
    localparam logic [31:0] BASE = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready, rsp_valid, rsp_fault, rsp_host;
    logic [47:0] rsp_paddr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        inval_all = 1'b0, fault_clear = 1'b0;
    logic        fault_valid;
    logic [31:0] fault_vaddr;
    logic [1:0]  fault_cause;

    addr_xlate_unit #(.ENTRIES(N), .TABLE_BASE(BASE)) uut (.*);

    always #2.5 clk = ~clk;

    int n_tests = 0, n_fail = 0;

    // reference model state
    bit          mv    [N];
    logic [19:0] mvpn  [N];
    bit          mhost [N];
    bit          mwr   [N];
    logic [35:0] mppn  [N];
    int          mrr = 0;
    logic [63:0] pt [int];
    bit          fv = 0;
    logic [31:0] fva = '0;
    logic [1:0]  fc = '0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_pte(bit host, bit wr, logic [35:0] ppn);
        return {16'h0, ppn, 9'h0, wr, host, 1'b1};
    endfunction

    function automatic int m_find(logic [19:0] vpn);
        for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == vpn) return i;
        return -1;
    endfunction

    task automatic check_fault_reg(input string req);
        chk(req, "fault_valid", fault_valid, fv);
        chk(req, "fault_vaddr", fault_vaddr, fva);
        chk(req, "fault_cause", fault_cause, fc);
    endtask

    // side: 0 none, 1 inval_all at the finishing edge, 2 fault_clear at it
    task automatic xlate(input logic [31:0] va, input bit wr, input int lat,
                         input int side, input string tag);
        logic [19:0] vpn;
        logic [63:0] e;
        logic [35:0] p;
        logic [47:0] epa;
        logic [1:0]  cause;
        bit present, h, w, hit;
        int idx, vic;
        vpn = va[31:12];
        idx = m_find(vpn);
        hit = (idx >= 0);
        e = '0;
        if (hit) begin
            present = 1; h = mhost[idx]; w = mwr[idx]; p = mppn[idx];
        end else begin
            if (pt.exists(int'(vpn))) e = pt[int'(vpn)];
            present = e[0]; h = e[1]; w = e[2]; p = e[47:12];
            if (!h) p[35:16] = '0;
        end
        cause = !present ? 2'd1 : ((wr && !w) ? 2'd2 : 2'd0);
        epa   = (cause != 0) ? 48'h0 : {p, va[11:0]};

        @(negedge clk);
        chk("R2", {tag, " idle rsp_valid"}, rsp_valid, 0);
        chk("R4", {tag, " ready before"}, req_ready, 1);
        req_valid = 1; req_vaddr = va; req_write = wr;
        if (hit) begin inval_all = (side == 1); fault_clear = (side == 2); end
        @(negedge clk);
        req_valid = 0; inval_all = 0; fault_clear = 0;
        if (!hit) begin
            chk("R4", {tag, " rsp during walk"}, rsp_valid, 0);
            chk("R4", {tag, " ready during walk"}, req_ready, 0);
            chk("R4", {tag, " rd_valid"}, mem_rd_valid, 1);
            chk("R4", {tag, " rd_addr"}, mem_rd_addr, BASE + {9'h0, vpn, 3'b000});
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                chk("R4", {tag, " rd hold"}, mem_rd_valid, 1);
                chk("R4", {tag, " addr hold"}, mem_rd_addr, BASE + {9'h0, vpn, 3'b000});
                chk("R4", {tag, " rsp wait"}, rsp_valid, 0);
            end
            mem_rd_ack = 1; mem_rd_data = e;
            inval_all = (side == 1); fault_clear = (side == 2);
            @(negedge clk);
            mem_rd_ack = 0; mem_rd_data = '0; inval_all = 0; fault_clear = 0;
        end else begin
            chk("R2", {tag, " no table read"}, mem_rd_valid, 0);
        end
        chk(tag, "rsp_valid", rsp_valid, 1);
        chk(tag, "rsp_fault", rsp_fault, cause != 0);
        chk(tag, "rsp_host", rsp_host, (cause == 0) && h);
        chk(tag, "rsp_paddr", rsp_paddr, epa);
        chk("R4", {tag, " ready after"}, req_ready, 1);

        // model update
        if (!hit && present && side != 1) begin
            vic = -1;
            for (int i = N - 1; i >= 0; i--) if (!mv[i]) vic = i;
            if (vic < 0) begin vic = mrr; mrr = (mrr + 1) % N; end
            mv[vic] = 1; mvpn[vic] = vpn; mhost[vic] = h; mwr[vic] = w; mppn[vic] = p;
        end
        if (side == 1) for (int i = 0; i < N; i++) mv[i] = 0;
        if (cause != 0 && (!fv || side == 2)) begin
            fv = 1; fva = va; fc = cause;
        end else if (side == 2) begin
            fv = 0; fva = '0; fc = '0;
        end
        check_fault_reg("R8");
    endtask

    task automatic pulse_inval();
        @(negedge clk); inval_all = 1;
        @(negedge clk); inval_all = 0;
        for (int i = 0; i < N; i++) mv[i] = 0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); fault_clear = 1;
        @(negedge clk); fault_clear = 0;
        fv = 0; fva = '0; fc = '0;
        check_fault_reg("R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R4 watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) mv[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "mem_rd_valid", mem_rd_valid, 0);
        chk("R1", "fault_valid", fault_valid, 0);

        pt[1] = mk_pte(0, 1, 36'h1_2345_ABCD);   // local, writable, high bits masked
        pt[2] = mk_pte(1, 0, 36'h9_8765_4321);   // host, read-only

        xlate(32'h0000_1123, 0, 2, 0, "R1");     // first access walks
        xlate(32'h0000_1FFF, 1, 0, 0, "R2");     // hit, write allowed
        xlate(32'h0000_1004, 0, 0, 0, "R3");     // local formatting
        xlate(32'h0000_2456, 0, 1, 0, "R5");     // host fill
        xlate(32'h0000_2ABC, 0, 0, 0, "R3");     // host hit
        xlate(32'h0000_2010, 1, 0, 0, "R7");     // write to read-only page
        xlate(32'h0000_3000, 0, 3, 0, "R6");     // no mapping, register stays sticky
        xlate(32'h0000_3008, 0, 0, 0, "R6");     // walks again
        pulse_clear();
        xlate(32'h0000_3abc, 0, 1, 0, "R6");     // captured after clear
        xlate(32'h0000_2ff0, 1, 0, 2, "R8");     // clear + new fault same edge
        pt[4] = mk_pte(0, 0, 36'h0_0000_0777);
        xlate(32'h0000_4100, 1, 2, 0, "R7");     // permission fault on walk, still cached
        xlate(32'h0000_4104, 0, 0, 0, "R7");     // read of it hits
        xlate(32'h0000_1200, 0, 0, 1, "R10");    // hit during invalidate completes
        xlate(32'h0000_1200, 0, 1, 1, "R10");    // fill discarded
        xlate(32'h0000_1204, 0, 0, 0, "R10");    // walks again

        pulse_inval();
        for (int v = 16; v < 33; v++) pt[v] = mk_pte(v[0], 1, 36'(v * 3 + 36'h1_0000_0000));
        for (int v = 16; v < 32; v++) xlate({12'h0, 8'(v), 12'h010}, 0, v % 3, 0, "R9");
        xlate({12'h0, 8'd16, 12'h020}, 0, 0, 0, "R9");
        xlate({12'h0, 8'd31, 12'h020}, 0, 0, 0, "R9");
        xlate({12'h0, 8'd32, 12'h030}, 0, 1, 0, "R9");   // evicts slot 0
        xlate({12'h0, 8'd17, 12'h040}, 0, 0, 0, "R9");
        xlate({12'h0, 8'd16, 12'h050}, 0, 2, 0, "R9");   // evicts slot 1
        xlate({12'h0, 8'd17, 12'h060}, 0, 0, 0, "R9");
        pulse_inval();                                   // pointer survives
        xlate({12'h0, 8'd20, 12'h070}, 0, 0, 0, "R10");

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule